// File: doc/BRIEF.md
# Five-Level Vectored Interrupt Controller

This block collects five interrupt request lines and decides which one a processor core should service next. The requests have a fixed priority order. One non-maskable line always wins. Three maskable lines each carry a hardwired 16-bit vector address. The lowest line has no vector of its own: on acceptance the core must fetch an instruction from the bus. All maskable lines pass through a global enable, and the three vectored maskable lines also pass through individual mask bits.

The core controls the block through three strobes: global-enable set, global-enable clear, and a mask load. A mask load writes the three mask bits and can also discard a latched edge request. At each instruction boundary the core raises an accept strobe. If a request is pending at that moment, it is taken: the global enable drops and the winning edge latch is consumed. A separate combinational decoder examines an opcode fetched for the lowest line. A restart opcode yields its target address. Any other opcode is flagged as a call that needs two more bytes.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `irq_pend_o` is 0, the global enable is off, all three mask bits are set (masked) and both edge latches are empty.
- R2: Among the qualified requests, priority from highest to lowest is `nmi_i` (vector 0x0024), `edge_i` (0x003C), `lvl_hi_i` (0x0034), `lvl_lo_i` (0x002C), `ext_i`. When `ext_i` wins, `vec_ext_o` is 1 and `vec_o` is 0x0000. Otherwise `vec_ext_o` is 0.
- R3: `nmi_i` ignores the global enable and the masks. A 0-to-1 change sampled at a clock edge latches it. It stays pending only while `nmi_i` remains 1. The latch empties when the input falls or when the request is accepted, so a held-high input does not re-trigger.
- R4: `en_set_i` turns the global enable on and `en_clr_i` turns it off, both at the next clock edge. While the enable is off, none of `edge_i`, `lvl_hi_i`, `lvl_lo_i` or `ext_i` can make `irq_pend_o` 1.
- R5: `mask_wr_i` loads the masks from `mask_data_i`: bit 0 masks `lvl_lo_i`, bit 1 masks `lvl_hi_i` and bit 2 masks `edge_i`, where 1 means masked. `ext_i` has no mask bit.
- R6: A 0-to-1 change on `edge_i` sets a latch even while that line is masked or the enable is off. The latch holds after the input falls. It empties when the line's request is accepted, or when a mask load has `mask_data_i` bit 3 set. A new rising edge in the same cycle keeps it set.
- R7: `ack_i` while `irq_pend_o` is 1 turns the global enable off at that clock edge, taking precedence over a simultaneous `en_set_i`. `ack_i` with nothing pending changes nothing.
- R8: For `opcode_i` of the form 11nnn111b, `opc_is_call_o` is 0 and `rst_vec_o` is n*8. For every other opcode, `opc_is_call_o` is 1 and `rst_vec_o` is 0.
- R9: `lvl_hi_i`, `lvl_lo_i` and `ext_i` are level-sensitive and are not stored. Each counts as a request only while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nmi_i | input | 1 | Non-maskable request, edge-latched, level-qualified |
| edge_i | input | 1 | Highest maskable request, rising-edge latched |
| lvl_hi_i | input | 1 | Middle maskable request, level |
| lvl_lo_i | input | 1 | Low maskable request, level |
| ext_i | input | 1 | Lowest request, needs an instruction from the bus |
| en_set_i | input | 1 | Global enable set strobe |
| en_clr_i | input | 1 | Global enable clear strobe |
| mask_wr_i | input | 1 | Mask load strobe |
| mask_data_i | input | 4 | Mask bits [2:0] and edge-latch discard bit [3] |
| ack_i | input | 1 | Instruction-boundary accept strobe |
| opcode_i | input | 8 | Opcode fetched for the lowest line |
| irq_pend_o | output | 1 | A qualified request is pending |
| vec_o | output | 16 | Vector of the winning request |
| vec_ext_o | output | 1 | Winner needs an instruction fetched from the bus |
| rst_vec_o | output | 16 | Target address decoded from `opcode_i` |
| opc_is_call_o | output | 1 | `opcode_i` is not a restart, so two more bytes follow |

## Verification
On every cycle, the assertions check three things. A live non-maskable request always yields 0x0024. Nothing maskable surfaces while the global enable is off. An accept always drops the enable. They also check that the edge latch only empties on its two clear conditions, and that the decoder output stays aligned and in range. The bench's scenarios are needed for the rest. These cover the full priority and mask interplay among the level lines, and the latch surviving a masked period and its input falling. They also cover the non-maskable line not re-triggering while held high, an accept beating a simultaneous enable, and every one of the 256 opcodes.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC  = 5;
  localparam int VEC_W = 16;
  localparam int OPC_W = 8;
  localparam int SRC_W = $clog2(NSRC);

  // index equals priority rank: larger index wins
  localparam int SRC_EXT  = 0;
  localparam int SRC_LO   = 1;
  localparam int SRC_HI   = 2;
  localparam int SRC_EDGE = 3;
  localparam int SRC_NMI  = 4;

  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    case (idx)
      SRC_NMI:  vec_of = VEC_W'(16'h0024);
      SRC_EDGE: vec_of = VEC_W'(16'h003C);
      SRC_HI:   vec_of = VEC_W'(16'h0034);
      SRC_LO:   vec_of = VEC_W'(16'h002C);
      default:  vec_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/irqv_edge_latch.sv
module irqv_edge_latch #(
  parameter bit LEVEL_QUAL = 1'b0
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic clr_i,
  output logic lat_o,
  output logic pend_o
);
  logic prev_q, lat_q, lat_d, rise;

  assign rise = sig_i & ~prev_q;

  always_comb begin
    lat_d = lat_q;
    if (rise)
      lat_d = 1'b1;
    else if (clr_i)
      lat_d = 1'b0;
    else if (LEVEL_QUAL && !sig_i)
      lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= sig_i;
      lat_q  <= lat_d;
    end
  end

  assign lat_o = lat_q;

  generate
    if (LEVEL_QUAL) begin : g_qual
      assign pend_o = lat_q & sig_i;
    end else begin : g_plain
      assign pend_o = lat_q;
    end
  endgenerate
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
(
  input  logic [NSRC-1:0]  req_i,
  output logic             pend_o,
  output logic [NSRC-1:0]  gnt_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ext_o
);
  always_comb begin
    gnt_o = '0;
    vec_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        vec_o = vec_of(i);
      end
    end
    pend_o = |req_i;
    ext_o  = gnt_o[SRC_EXT];
  end
endmodule

// File: rtl/irqv_opdec.sv
module irqv_opdec
  import irqv_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output logic [VEC_W-1:0] tgt_o,
  output logic             call_o
);
  localparam int NUM_W = 3;
  localparam int SHIFT = 3;
  logic is_restart;

  assign is_restart = (opcode_i[OPC_W-1 -: 2] == 2'b11) && (opcode_i[2:0] == 3'b111);
  assign call_o     = ~is_restart;
  assign tgt_o      = is_restart
                    ? VEC_W'({opcode_i[SHIFT +: NUM_W], {SHIFT{1'b0}}})
                    : '0;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_i,
  input  logic             edge_i,
  input  logic             lvl_hi_i,
  input  logic             lvl_lo_i,
  input  logic             ext_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             mask_wr_i,
  input  logic [3:0]       mask_data_i,
  input  logic             ack_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             irq_pend_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_ext_o,
  output logic [VEC_W-1:0] rst_vec_o,
  output logic             opc_is_call_o
);
  localparam int NMASK = 3;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic             gie_q, gie_d;
  logic [NMASK-1:0] mask_q, mask_d;
  logic [NSRC-1:0]  req, gnt;
  logic             accept, nmi_pend, nmi_lat, edge_lat, edge_pend;
  logic             edge_clr, nmi_clr;

  assign accept   = ack_i & irq_pend_o;
  assign nmi_clr  = accept & gnt[SRC_NMI];
  assign edge_clr = (accept & gnt[SRC_EDGE]) | (mask_wr_i & mask_data_i[3]);

  irqv_edge_latch #(.LEVEL_QUAL(1'b1)) u_nmi_lat (
    .clk(clk), .rst_ni(rst_q), .sig_i(nmi_i), .clr_i(nmi_clr),
    .lat_o(nmi_lat), .pend_o(nmi_pend)
  );

  irqv_edge_latch #(.LEVEL_QUAL(1'b0)) u_edge_lat (
    .clk(clk), .rst_ni(rst_q), .sig_i(edge_i), .clr_i(edge_clr),
    .lat_o(edge_lat), .pend_o(edge_pend)
  );

  always_comb begin
    req           = '0;
    req[SRC_NMI]  = nmi_pend;
    req[SRC_EDGE] = gie_q & edge_pend & ~mask_q[2];
    req[SRC_HI]   = gie_q & lvl_hi_i  & ~mask_q[1];
    req[SRC_LO]   = gie_q & lvl_lo_i  & ~mask_q[0];
    req[SRC_EXT]  = gie_q & ext_i;
  end

  irqv_arbiter u_arb (
    .req_i(req), .pend_o(irq_pend_o), .gnt_o(gnt), .vec_o(vec_o), .ext_o(vec_ext_o)
  );

  irqv_opdec u_dec (
    .opcode_i(opcode_i), .tgt_o(rst_vec_o), .call_o(opc_is_call_o)
  );

  // next state
  always_comb begin
    gie_d  = gie_q;
    mask_d = mask_q;
    if (accept || en_clr_i)
      gie_d = 1'b0;
    else if (en_set_i)
      gie_d = 1'b1;
    if (mask_wr_i)
      mask_d = mask_data_i[NMASK-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      gie_q  <= 1'b0;
      mask_q <= '1;
    end else begin
      gie_q  <= gie_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk
  import irqv_pkg::*;
(
  input logic             clk,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             irq_pend_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_ext_o,
  input logic             gie_q,
  input logic             nmi_pend,
  input logic             edge_lat,
  input logic             mask_wr_i,
  input logic [3:0]       mask_data_i,
  input logic [VEC_W-1:0] rst_vec_o,
  input logic             opc_is_call_o
);
  p_nmi_top_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    nmi_pend |-> (irq_pend_o && vec_o == 16'h0024 && !vec_ext_o));

  p_ext_zero_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    vec_ext_o |-> (irq_pend_o && vec_o == '0));

  p_gie_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!gie_q && !nmi_pend) |-> !irq_pend_o);

  p_ack_drops_gie_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && irq_pend_o) |=> !gie_q);

  p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (edge_lat && !(ack_i && irq_pend_o && vec_o == 16'h003C)
              && !(mask_wr_i && mask_data_i[3])) |=> edge_lat);

  p_dec_range_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    opc_is_call_o ? (rst_vec_o == '0)
                  : (rst_vec_o[2:0] == 3'b000 && rst_vec_o[VEC_W-1:6] == '0));
endmodule

bind irq_vec_ctrl irqv_chk u_chk (
  .clk(clk), .rst_ni(rst_q), .ack_i(ack_i), .irq_pend_o(irq_pend_o),
  .vec_o(vec_o), .vec_ext_o(vec_ext_o), .gie_q(gie_q), .nmi_pend(nmi_pend),
  .edge_lat(edge_lat), .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i),
  .rst_vec_o(rst_vec_o), .opc_is_call_o(opc_is_call_o)
);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic nmi_i, edge_i, lvl_hi_i, lvl_lo_i, ext_i;
  logic en_set_i, en_clr_i, mask_wr_i, ack_i;
  logic [3:0] mask_data_i;
  logic [7:0] opcode_i;
  logic irq_pend_o, vec_ext_o, opc_is_call_o;
  logic [15:0] vec_o, rst_vec_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .edge_i(edge_i),
    .lvl_hi_i(lvl_hi_i), .lvl_lo_i(lvl_lo_i), .ext_i(ext_i),
    .en_set_i(en_set_i), .en_clr_i(en_clr_i), .mask_wr_i(mask_wr_i),
    .mask_data_i(mask_data_i), .ack_i(ack_i), .opcode_i(opcode_i),
    .irq_pend_o(irq_pend_o), .vec_o(vec_o), .vec_ext_o(vec_ext_o),
    .rst_vec_o(rst_vec_o), .opc_is_call_o(opc_is_call_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic gie_on();  en_set_i = 1; step(); en_set_i = 0; endtask
  task automatic gie_off(); en_clr_i = 1; step(); en_clr_i = 0; endtask
  task automatic mask_load(input logic [3:0] d);
    mask_data_i = d; mask_wr_i = 1; step(); mask_wr_i = 0; mask_data_i = '0;
  endtask
  task automatic accept(); ack_i = 1; step(); ack_i = 0; endtask

  // pending / vector / ext flag together
  task automatic see(input string req, input logic p, input logic [15:0] v, input logic x);
    #1;
    chk(req, {15'd0, irq_pend_o, vec_o}, {15'd0, p, v});
    chk(req, {31'd0, vec_ext_o}, {31'd0, x});
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    rst_n = 0; nmi_i = 0; edge_i = 0; lvl_hi_i = 0; lvl_lo_i = 0; ext_i = 0;
    en_set_i = 0; en_clr_i = 0; mask_wr_i = 0; mask_data_i = '0; ack_i = 0; opcode_i = '0;
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();

    // R1 reset state
    see("R1 idle after reset", 0, 16'h0000, 0);
    lvl_hi_i = 1; lvl_lo_i = 1;
    see("R1 enable off after reset", 0, 16'h0000, 0);
    gie_on();
    see("R1 masks set after reset", 0, 16'h0000, 0);
    ext_i = 1;
    see("R2 ext unmaskable vector flag", 1, 16'h0000, 1);
    lvl_hi_i = 0; lvl_lo_i = 0; ext_i = 0;

    // R2 R4 R5 R9 sweep of masks, enable and level lines
    for (int m = 0; m < 4; m++) begin
      for (int g = 0; g < 2; g++) begin
        for (int p = 0; p < 8; p++) begin
          logic rh, rl, re;
          logic [15:0] ev;
          lvl_hi_i = 0; lvl_lo_i = 0; ext_i = 0;
          mask_load({2'b01, m[1], m[0]});
          if (g == 1) gie_on(); else gie_off();
          lvl_hi_i = p[2]; lvl_lo_i = p[1]; ext_i = p[0];
          rh = p[2] & ~m[1] & g[0];
          rl = p[1] & ~m[0] & g[0];
          re = p[0] & g[0];
          ev = rh ? 16'h0034 : (rl ? 16'h002C : 16'h0000);
          see("R2 R4 R5 R9 level sweep", rh | rl | re, ev, ~rh & ~rl & re);
        end
      end
    end
    lvl_hi_i = 0; lvl_lo_i = 0; ext_i = 0;

    // R6 edge latch
    gie_off();
    mask_load(4'b0111);
    edge_i = 1; step(); edge_i = 0; step();
    see("R6 masked edge not pending", 0, 16'h0000, 0);
    mask_load(4'b0011);
    see("R4 edge blocked by enable", 0, 16'h0000, 0);
    gie_on();
    see("R6 latch kept through mask", 1, 16'h003C, 0);
    lvl_hi_i = 1; ext_i = 1;
    mask_load(4'b0000);
    see("R2 edge beats middle", 1, 16'h003C, 0);
    accept();
    see("R7 accept drops enable", 0, 16'h0000, 0);
    gie_on();
    see("R6 accept empties latch", 1, 16'h0034, 0);
    lvl_hi_i = 0;
    see("R9 level line released", 1, 16'h0000, 1);
    ext_i = 0;
    edge_i = 1; step(); edge_i = 0;
    see("R6 new edge latched", 1, 16'h003C, 0);
    mask_load(4'b1000);
    see("R6 discard bit empties latch", 0, 16'h0000, 0);

    // R3 non-maskable line
    gie_off();
    mask_load(4'b0111);
    nmi_i = 1; step();
    see("R3 nmi ignores enable", 1, 16'h0024, 0);
    nmi_i = 0;
    see("R3 nmi needs input high", 0, 16'h0000, 0);
    step();
    nmi_i = 1; step();
    see("R3 nmi second edge", 1, 16'h0024, 0);
    accept();
    see("R3 held nmi not retriggered", 0, 16'h0000, 0);
    step();
    see("R3 held nmi still quiet", 0, 16'h0000, 0);
    nmi_i = 0; step();

    // R7 accept interplay
    gie_on();
    nmi_i = 1; step();
    accept();
    nmi_i = 0;
    mask_load(4'b0000);
    ext_i = 1;
    see("R7 nmi accept drops enable", 0, 16'h0000, 0);
    gie_on();
    see("R4 enable set again", 1, 16'h0000, 1);
    ack_i = 1; en_set_i = 1; step(); ack_i = 0; en_set_i = 0;
    see("R7 accept beats enable set", 0, 16'h0000, 0);
    ext_i = 0;
    gie_on();
    accept();
    ext_i = 1;
    see("R7 idle accept no effect", 1, 16'h0000, 1);
    ext_i = 0;

    // R8 opcode decoder, all codes
    for (int o = 0; o < 256; o++) begin
      logic [7:0] ob;
      logic ec;
      logic [15:0] et;
      ob = 8'(o);
      ec = !((ob[7:6] == 2'b11) && (ob[2:0] == 3'b111));
      et = ec ? 16'h0000 : 16'(((o >> 3) & 7) * 8);
      opcode_i = ob;
      #1;
      chk("R8 decoder", {15'd0, opc_is_call_o, rst_vec_o}, {15'd0, ec, et});
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule